// File: doc/BRIEF.md
# Pipeline Hazard Stall and Operand-Forwarding Control

This block holds the data-hazard control of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it compares the two source register fields of the instruction in decode with the destination fields of the instructions in execute, memory and writeback. From that it decides whether decode must hold. When it asserts `stall`, the fetch and decode registers keep their contents and a bubble enters execute. It also produces, for the instruction that sits in execute, one operand-select code per source. The external operand multiplexers use these codes to take either the register file or a result held further down the pipe.

A static input, `fwd_mode`, picks one of two resolution schemes. With forwarding off, a consumer waits in decode until its producer has left writeback. With forwarding on, only a load followed at once by a user of its result costs a cycle. Every other dependency is met by the select codes. Select code 00 means the register file as read when the instruction enters execute. By then that read sees every write that finished before that cycle.

The surrounding pipeline marks a bubble by clearing its write and load flags, so a bubble never counts as a producer.

Top module: `hzd_ctrl`

## Requirements
- R1: With `fwd_mode`=0, `stall` is high in the same cycle whenever a used, nonzero decode source equals the destination of a writing instruction in execute, memory or writeback.
- R2: With `fwd_mode`=0, a consumer one, two or three instructions behind its producer is held for 3, 2 or 1 cycles. At four or more positions it is not held.
- R3: With `fwd_mode`=1, `stall` is high only when execute holds a writing load (`ex_load`=1, `ex_wr`=1) whose destination equals a used, nonzero decode source. A load used by the next instruction costs exactly one stall cycle. A load two positions ahead and any ALU producer cost none.
- R4: `fwd_a` and `fwd_b` are registered and apply to the instruction in execute. The code is 01 (take the execute/memory result) when the producer is one position ahead, meaning it was in execute while the consumer was in decode. It is 10 (take the memory/writeback result) when the producer is two positions ahead, meaning it was in memory then. Otherwise it is 00 (register file). Code 11 never appears.
- R5: When both of those producers write the register a source reads, the younger one wins and the code is 01.
- R6: Register 0, a source whose used flag is low, and an instruction whose write flag is low never cause a stall or a nonzero select.
- R7: In the cycle after `stall` was high, both select codes are 00, because a bubble occupies execute.
- R8: With `fwd_mode`=0, both select codes are always 00.
- R9: Take the program of three load/add pairs, closed by an add-immediate, with r1=0, r2=2, r5=5 and memory words 5,4,3,2,... From the first fetch to the last writeback it takes 24 cycles with 12 stall cycles when forwarding is off, and 15 cycles with 3 stall cycles when forwarding is on. r2 ends at 15 in both cases.
- R10: After reset both select codes are 00. `stall` depends only on the present inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fwd_mode | input | 1 | Static scheme select: 0 waits for writeback, 1 forwards |
| id_rs1 | input | REG_AW | First source register of the decode instruction |
| id_rs1_used | input | 1 | First source is read |
| id_rs2 | input | REG_AW | Second source register of the decode instruction |
| id_rs2_used | input | 1 | Second source is read |
| ex_rd | input | REG_AW | Destination of the execute instruction |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_AW | Destination of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | REG_AW | Destination of the writeback instruction |
| wb_wr | input | 1 | Writeback instruction writes a register |
| stall | output | 1 | Hold fetch and decode, insert a bubble into execute |
| fwd_a | output | 2 | Operand select for the first source of the execute instruction |
| fwd_b | output | 2 | Operand select for the second source of the execute instruction |

## Verification
The bench wraps the block in a small pipeline model with a register file and data memory, so that the codes it emits are shown to steer real values. Directed programs place a producer at distances one to four, with either an ALU or a load producer. This separates the three stall counts of the waiting scheme from the single load-use stall of the forwarding scheme. Further programs write the same register twice in a row, write register 0, or carry a matching but unused source field. These isolate the younger-producer priority and the cases that must be ignored. Random programs over a handful of registers, run in both modes, then compare every cycle's stall and select codes with bench predictions and the final registers with a sequential execution.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [1:0] {
    SEL_RF    = 2'b00,
    SEL_EXMEM = 2'b01,
    SEL_MEMWB = 2'b10
  } opsel_e;

  // Operand source for an instruction about to enter EX; younger producer first.
  function automatic opsel_e choose_sel(input logic fwd_on, input logic hit_ex,
                                        input logic hit_mem);
    if (!fwd_on)       return SEL_RF;
    else if (hit_ex)   return SEL_EXMEM;
    else if (hit_mem)  return SEL_MEMWB;
    else               return SEL_RF;
  endfunction

  // Whether one decode source must hold decode this cycle.
  function automatic logic need_hold(input logic fwd_on, input logic hit_ex,
                                     input logic ex_is_load, input logic hit_mem,
                                     input logic hit_wb);
    if (fwd_on) return hit_ex & ex_is_load;
    else        return hit_ex | hit_mem | hit_wb;
  endfunction

endpackage

// File: rtl/hzd_cmp.sv
module hzd_cmp #(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] src,
  input  logic              used,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wr,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wr,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wr,
  output logic              hit_ex,
  output logic              hit_mem,
  output logic              hit_wb
);

  logic live;  // source actually reads a real register
  assign live = used && (src != '0);

  assign hit_ex  = live && ex_wr  && (ex_rd  == src);
  assign hit_mem = live && mem_wr && (mem_rd == src);
  assign hit_wb  = live && wb_wr  && (wb_rd  == src);

  p_zero_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((src == '0) || !used) |-> !(hit_ex || hit_mem || hit_wb));
  p_silent_writer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_wr && !mem_wr && !wb_wr) |-> !(hit_ex || hit_mem || hit_wb));

endmodule

// File: rtl/hzd_resolve.sv
module hzd_resolve
  import hzd_pkg::*;
#(
  parameter int NSRC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fwd_mode,
  input  logic                 ex_is_load,
  input  logic [NSRC-1:0]      hit_ex,
  input  logic [NSRC-1:0]      hit_mem,
  input  logic [NSRC-1:0]      hit_wb,
  output logic                 stall,
  output logic [NSRC-1:0][1:0] sel_nxt
);

  logic [NSRC-1:0] hold_src;
  logic            load_use;   // forwarding scheme: load result not ready yet
  logic            wait_wb;    // waiting scheme: producer still in flight

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      hold_src[i] = need_hold(fwd_mode, hit_ex[i], ex_is_load, hit_mem[i], hit_wb[i]);
      sel_nxt[i]  = choose_sel(fwd_mode, hit_ex[i], hit_mem[i]);
    end
  end

  assign load_use = fwd_mode  && (|hold_src);
  assign wait_wb  = !fwd_mode && (|hold_src);
  assign stall    = load_use || wait_wb;

  p_wait_any_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwd_mode && (|(hit_ex | hit_mem | hit_wb))) |-> stall);
  p_load_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_mode && stall) |-> (ex_is_load && (|hit_ex)));
  p_young_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_mode && hit_ex[0] && hit_mem[0]) |-> (sel_nxt[0] == SEL_EXMEM));

endmodule

// File: rtl/hzd_selreg.sv
module hzd_selreg #(
  parameter int NSRC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fwd_mode,
  input  logic                 stall,
  input  logic [NSRC-1:0][1:0] sel_nxt,
  output logic [NSRC-1:0][1:0] sel_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= '0;
    else if (stall) sel_q <= '0;      // bubble enters EX
    else            sel_q <= sel_nxt;
  end

  p_bubble_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (sel_q == '0));
  p_nofwd_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_mode |=> (sel_q == '0));

  for (genvar g = 0; g < NSRC; g++) begin : g_code
    p_legal_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q[g] != 2'b11);
  end

endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl #(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd_mode,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic              id_rs1_used,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_rs2_used,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wr,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wr,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wr,
  output logic              stall,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b
);

  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_AW-1:0] src_reg;
  logic [NSRC-1:0]             src_used;
  logic [NSRC-1:0]             hit_ex, hit_mem, hit_wb;
  logic [NSRC-1:0][1:0]        sel_nxt, sel_q;
  logic                        ex_is_load;

  assign src_reg[0]  = id_rs1;
  assign src_reg[1]  = id_rs2;
  assign src_used[0] = id_rs1_used;
  assign src_used[1] = id_rs2_used;
  assign ex_is_load  = ex_load && ex_wr;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hzd_cmp #(.REG_AW(REG_AW)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (src_reg[g]),
      .used   (src_used[g]),
      .ex_rd  (ex_rd),
      .ex_wr  (ex_wr),
      .mem_rd (mem_rd),
      .mem_wr (mem_wr),
      .wb_rd  (wb_rd),
      .wb_wr  (wb_wr),
      .hit_ex (hit_ex[g]),
      .hit_mem(hit_mem[g]),
      .hit_wb (hit_wb[g])
    );
  end

  hzd_resolve #(.NSRC(NSRC)) u_resolve (
    .clk       (clk),
    .rst_n     (rst_n),
    .fwd_mode  (fwd_mode),
    .ex_is_load(ex_is_load),
    .hit_ex    (hit_ex),
    .hit_mem   (hit_mem),
    .hit_wb    (hit_wb),
    .stall     (stall),
    .sel_nxt   (sel_nxt)
  );

  hzd_selreg #(.NSRC(NSRC)) u_selreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .fwd_mode(fwd_mode),
    .stall   (stall),
    .sel_nxt (sel_nxt),
    .sel_q   (sel_q)
  );

  assign fwd_a = sel_q[0];
  assign fwd_b = sel_q[1];

  p_forward_needs_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b00 || fwd_b != 2'b00) |-> fwd_mode);

endmodule

// File: tb/hzd_ctrl_test.sv
`timescale 1ns/1ps
module hzd_ctrl_test;

  localparam int AW = 5;

  typedef struct packed {
    logic       v, wr, ld, u1, u2;
    logic [4:0] rd, rs1, rs2;
    logic [7:0] imm;
  } ins_t;

  int total = 0, bad = 0;
  bit finished = 0;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n, fwd_mode;
  logic [AW-1:0] id_rs1, id_rs2, ex_rd, mem_rd, wb_rd;
  logic id_rs1_used, id_rs2_used, ex_wr, ex_load, mem_wr, wb_wr;
  logic stall;
  logic [1:0] fwd_a, fwd_b;

  hzd_ctrl #(.REG_AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .fwd_mode(fwd_mode),
    .id_rs1(id_rs1), .id_rs1_used(id_rs1_used),
    .id_rs2(id_rs2), .id_rs2_used(id_rs2_used),
    .ex_rd(ex_rd), .ex_wr(ex_wr), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .wb_rd(wb_rd), .wb_wr(wb_wr),
    .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  ins_t prog [64];
  int   nprog;
  logic [31:0] rf_init [32];
  logic [31:0] rf [32];
  logic [31:0] gold [32];
  logic [31:0] dmem [8];
  ins_t id_s, ex_s, mem_s, wb_s;
  logic [31:0] mem_res, wb_res;
  int run_cycles, run_stalls;

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic ins_t mk(input bit ld, input bit wr, input int rd,
                              input int rs1, input bit u1, input int rs2,
                              input bit u2, input int imm);
    ins_t c;
    c.v = 1; c.wr = wr; c.ld = ld; c.u1 = u1; c.u2 = u2;
    c.rd = 5'(rd); c.rs1 = 5'(rs1); c.rs2 = 5'(rs2); c.imm = 8'(imm);
    return c;
  endfunction

  function automatic ins_t nop();
    return mk(0, 0, 0, 0, 0, 0, 0, 0);
  endfunction

  // does producer p create a value that consumer c reads?
  function automatic bit feeds(input ins_t p, input ins_t c);
    if (!(p.v && p.wr) || p.rd == 0 || !c.v) return 0;
    return (c.u1 && c.rs1 == p.rd) || (c.u2 && c.rs2 == p.rd);
  endfunction

  // expected hold of decode: waiting scheme needs producer gone from WB,
  // forwarding scheme only stumbles on a load one position ahead
  function automatic bit exp_stall(input bit fm, input ins_t c, input ins_t d1,
                                   input ins_t d2, input ins_t d3);
    if (fm) return feeds(d1, c) && d1.ld;
    return feeds(d1, c) || feeds(d2, c) || feeds(d3, c);
  endfunction

  function automatic logic [1:0] exp_sel(input bit fm, input ins_t c, input bit second,
                                         input ins_t d1, input ins_t d2);
    logic [4:0] r;
    bit u;
    r = second ? c.rs2 : c.rs1;
    u = second ? c.u2 : c.u1;
    if (!fm || !c.v || !u || r == 0) return 2'b00;
    if (d1.v && d1.wr && d1.rd == r) return 2'b01;
    if (d2.v && d2.wr && d2.rd == r) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [31:0] alu(input ins_t c, input logic [31:0] a,
                                      input logic [31:0] b);
    if (c.ld)      return (a + 32'(c.imm)) & 32'd7;
    else if (c.u2) return a + b;
    else           return a + 32'(c.imm);
  endfunction

  task automatic golden_run();
    for (int i = 0; i < 32; i++) gold[i] = rf_init[i];
    for (int k = 0; k < nprog; k++) begin
      ins_t c;
      logic [31:0] r;
      c = prog[k];
      r = alu(c, gold[c.rs1], gold[c.rs2]);
      if (c.ld) r = dmem[r[2:0]];
      if (c.wr && c.rd != 0) gold[c.rd] = r;
    end
  endtask

  task automatic drive();
    id_rs1 = id_s.rs1; id_rs1_used = id_s.v && id_s.u1;
    id_rs2 = id_s.rs2; id_rs2_used = id_s.v && id_s.u2;
    ex_rd = ex_s.rd;   ex_wr = ex_s.v && ex_s.wr; ex_load = ex_s.v && ex_s.ld;
    mem_rd = mem_s.rd; mem_wr = mem_s.v && mem_s.wr;
    wb_rd = wb_s.rd;   wb_wr = wb_s.v && wb_s.wr;
  endtask

  task automatic run(input bit fm, input string name);
    int pc, retired, cyc, stalls;
    logic [1:0] ea, eb;
    bit prev_stall;
    id_s = '0; ex_s = '0; mem_s = '0; wb_s = '0; mem_res = 0; wb_res = 0;
    for (int i = 0; i < 32; i++) rf[i] = rf_init[i];
    fwd_mode = fm;
    rst_n = 0;
    drive();
    @(negedge clk); @(negedge clk);
    #1;
    chk($sformatf("R10 %s reset fwd_a", name), fwd_a, 0);
    chk($sformatf("R10 %s reset fwd_b", name), fwd_b, 0);
    chk($sformatf("R10 %s idle stall", name), stall, 0);
    rst_n = 1;
    pc = 0; retired = 0; cyc = 0; stalls = 0; ea = 0; eb = 0; prev_stall = 0;
    while (retired < nprog && cyc < 2000) begin
      bit s;
      logic [1:0] na, nb;
      logic [31:0] va, vb, ex_res;
      @(negedge clk);
      drive();
      #1;
      s = exp_stall(fm, id_s, ex_s, mem_s, wb_s);
      chk($sformatf("%s %s stall cyc%0d", fm ? "R3" : "R1", name, cyc), stall, s);
      if (!fm) begin
        chk($sformatf("R8 %s fwd_a cyc%0d", name, cyc), fwd_a, 0);
        chk($sformatf("R8 %s fwd_b cyc%0d", name, cyc), fwd_b, 0);
      end else if (prev_stall) begin
        chk($sformatf("R7 %s fwd_a cyc%0d", name, cyc), fwd_a, 0);
        chk($sformatf("R7 %s fwd_b cyc%0d", name, cyc), fwd_b, 0);
      end else begin
        chk($sformatf("R4 %s fwd_a cyc%0d", name, cyc), fwd_a, ea);
        chk($sformatf("R4 %s fwd_b cyc%0d", name, cyc), fwd_b, eb);
      end
      // operand values steered by the block's own codes
      va = (fwd_a == 2'b01) ? mem_res : (fwd_a == 2'b10) ? wb_res : rf[ex_s.rs1];
      vb = (fwd_b == 2'b01) ? mem_res : (fwd_b == 2'b10) ? wb_res : rf[ex_s.rs2];
      ex_res = alu(ex_s, va, vb);
      na = exp_sel(fm, id_s, 0, ex_s, mem_s);
      nb = exp_sel(fm, id_s, 1, ex_s, mem_s);
      @(posedge clk);
      cyc++;
      if (wb_s.v) begin
        if (wb_s.wr && wb_s.rd != 0) rf[wb_s.rd] = wb_res;
        retired++;
      end
      wb_s = mem_s;
      wb_res = mem_s.ld ? dmem[mem_res[2:0]] : mem_res;
      mem_s = ex_s;
      mem_res = ex_res;
      if (s) begin
        ex_s = '0; ea = 0; eb = 0; stalls++;
      end else begin
        ex_s = id_s; ea = na; eb = nb;
        if (pc < nprog) begin id_s = prog[pc]; pc++; end
        else id_s = '0;
      end
      prev_stall = s;
    end
    run_cycles = cyc;
    run_stalls = stalls;
    golden_run();
    for (int i = 0; i < 8; i++)
      chk($sformatf("R4 %s final r%0d", name, i), rf[i], gold[i]);
  endtask

  task automatic load_ldadd();
    nprog = 8;
    prog[0] = mk(1, 1, 2, 1, 1, 0, 0, 0);
    prog[1] = mk(1, 1, 5, 1, 1, 0, 0, 1);
    prog[2] = mk(0, 1, 2, 2, 1, 5, 1, 0);
    prog[3] = mk(1, 1, 5, 1, 1, 0, 0, 2);
    prog[4] = mk(0, 1, 2, 2, 1, 5, 1, 0);
    prog[5] = mk(1, 1, 5, 1, 1, 0, 0, 3);
    prog[6] = mk(0, 1, 2, 2, 1, 5, 1, 0);
    prog[7] = mk(0, 1, 2, 2, 1, 0, 0, 1);
  endtask

  // producer, gap-1 nops, consumer of r3
  task automatic load_dist(input bit is_load, input int gap);
    nprog = 0;
    prog[nprog++] = is_load ? mk(1, 1, 3, 6, 1, 0, 0, 1) : mk(0, 1, 3, 6, 1, 6, 1, 0);
    for (int k = 1; k < gap; k++) prog[nprog++] = nop();
    prog[nprog++] = mk(0, 1, 4, 3, 1, 0, 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL R10 watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) rf_init[i] = 32'(10 + i);
    rf_init[0] = 0; rf_init[1] = 0; rf_init[2] = 2; rf_init[5] = 5; rf_init[6] = 16;
    for (int i = 0; i < 8; i++) dmem[i] = (i < 6) ? 32'(5 - i) : 32'(20 + i);

    // R9: load/load/add program in both schemes
    for (int m = 0; m < 2; m++) begin
      load_ldadd();
      run(m[0], m[0] ? "ldadd_fwd" : "ldadd_wait");
      chk("R9 cycles", run_cycles, m[0] ? 15 : 24);
      chk("R9 stalls", run_stalls, m[0] ? 3 : 12);
      chk("R9 final r2", rf[2], 15);
    end

    // R2: waiting scheme by distance
    for (int d = 1; d <= 4; d++) begin
      load_dist(0, d);
      run(0, $sformatf("wait_d%0d", d));
      chk($sformatf("R2 stalls at distance %0d", d), run_stalls, (d < 4) ? 4 - d : 0);
    end
    // R3: forwarding scheme, ALU and load producers
    for (int d = 1; d <= 3; d++) begin
      load_dist(0, d);
      run(1, $sformatf("fwd_alu_d%0d", d));
      chk($sformatf("R3 alu stalls at distance %0d", d), run_stalls, 0);
      load_dist(1, d);
      run(1, $sformatf("fwd_ld_d%0d", d));
      chk($sformatf("R3 load stalls at distance %0d", d), run_stalls, (d == 1) ? 1 : 0);
    end

    // R5: two producers of r3 back to back
    nprog = 3;
    prog[0] = mk(0, 1, 3, 6, 1, 6, 1, 0);
    prog[1] = mk(0, 1, 3, 6, 1, 0, 0, 5);
    prog[2] = mk(0, 1, 4, 3, 1, 3, 1, 0);
    run(1, "prio");
    chk("R5 younger producer value r4", rf[4], 42);
    chk("R5 no stall", run_stalls, 0);

    // R6: register 0 and an unused matching field
    for (int m = 0; m < 2; m++) begin
      nprog = 2;
      prog[0] = mk(0, 1, 0, 6, 1, 6, 1, 0);
      prog[1] = mk(0, 1, 4, 0, 1, 0, 1, 0);
      run(m[0], "r0");
      chk("R6 r0 no stall", run_stalls, 0);
      chk("R6 r0 reads zero", rf[4], 0);
      nprog = 2;
      prog[0] = mk(1, 1, 3, 1, 1, 0, 0, 0);
      prog[1] = mk(0, 1, 4, 6, 1, 3, 0, 1);
      run(m[0], "unused");
      chk("R6 unused field no stall", run_stalls, 0);
      nprog = 2;
      prog[0] = mk(1, 0, 3, 1, 1, 0, 0, 0);
      prog[1] = mk(0, 1, 4, 3, 1, 3, 1, 0);
      run(m[0], "nowrite");
      chk("R6 non-writer no stall", run_stalls, 0);
    end

    // random programs in both schemes
    for (int t = 0; t < 24; t++) begin
      nprog = 24;
      for (int k = 0; k < nprog; k++) begin
        int kind;
        kind = int'($urandom % 5);
        case (kind)
          0: prog[k] = mk(1, 1, int'($urandom % 5), int'($urandom % 7), 1, 0, 0, int'($urandom % 8));
          1, 2: prog[k] = mk(0, 1, int'($urandom % 5), int'($urandom % 7), 1,
                             int'($urandom % 7), 1, 0);
          3: prog[k] = mk(0, 1, int'($urandom % 5), int'($urandom % 7), 1, 0, 0,
                          int'($urandom % 16));
          default: prog[k] = nop();
        endcase
      end
      run(t[0], $sformatf("rand%0d", t));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule